// File: doc/BRIEF.md
# Streaming Grid Word-Pattern Counter

This block counts word patterns in a rectangular letter grid that arrives one cell per clock cycle in row-major order. The row width is a fixed parameter. Every accepted cell is treated as the bottom-right corner of a set of small windows taken over the rows already received. Two totals are kept per frame.

The first total counts the four-letter word XMAS in straight lines. A line may be horizontal, vertical, on the leading diagonal or on the trailing diagonal, and it may read in either direction. The second total counts X-shaped crosses. Each cross is formed by two three-letter MAS words that share their middle A and lie on the two diagonals of a 3x3 square.

A frame is opened by a start-of-frame marker on its first cell and closed by an end-of-frame marker on its last cell. A one-cycle done pulse then marks the totals as final.

Top module: `grid_word_counter`

## Requirements
- R1: Only the uppercase ASCII bytes 0x58 (X), 0x4D (M), 0x41 (A) and 0x53 (S) can take part in a match. Every other byte, lowercase included, is a non-letter that never matches.
- R2: A horizontal run of four cells that ends at the current cell adds one to `straight_count` when, read left to right, it spells XMAS or SAMX.
- R3: A vertical run of four cells that ends at the current cell adds one to `straight_count` when, read top to bottom, it spells XMAS or SAMX.
- R4: The leading diagonal and the trailing diagonal of the 4x4 square that ends at the current cell are each checked for XMAS or SAMX. Each diagonal adds its own one.
- R5: In one accepted cell, the results of the horizontal, vertical and two diagonal checks are summed. That sum, from 0 to 4, is added to `straight_count`.
- R6: `x_count` adds one when the 3x3 square ending at the current cell meets three conditions: its centre is A, its top-left and bottom-right corners hold one M and one S, and its top-right and bottom-left corners hold one M and one S. The four edge-midpoint cells have no effect.
- R7: A window that would wrap across a row boundary, or reach above the first row of the frame, never produces a match. This holds even when cells of the previous row or the previous frame would complete the word.
- R8: An accepted cell that carries `in_sof` starts a new frame at row 0, column 0 and restarts both counts from zero. Reset also clears both counts and `done`.
- R9: `done` is high for exactly one cycle. That cycle directly follows the cycle that accepted a cell carrying `in_eof`. In that cycle both counts include every cell of the frame.
- R10: In cycles where `in_valid` is low, `in_char`, `in_sof` and `in_eof` are ignored and both counts hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | A grid cell is presented this cycle |
| in_sof | input | 1 | The presented cell is the first of a frame |
| in_eof | input | 1 | The presented cell is the last of a frame |
| in_char | input | 8 | ASCII byte of the presented cell |
| straight_count | output | CNT_W | Running count of straight XMAS/SAMX matches |
| x_count | output | CNT_W | Running count of X-shaped MAS crosses |
| done | output | 1 | One-cycle pulse after the last cell of a frame |

## Verification
A cell's matches are added at the clock edge that accepts the cell. Both counts are therefore valid from the next cycle on, and `done` rises in that same cycle after an end-of-frame cell. The bench drives stimulus on the falling edge and reads the counts and `done` on the falling edge after the final cell. At that point it expects `done` high, and on the falling edge after that it expects `done` low again. During idle gaps it reads the counts at the first and at the last idle falling edge and expects them to be equal.

// File: rtl/grid_word_counter.sv
module grid_word_counter #(
  parameter int COLS  = 8,
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic             in_sof,
  input  logic             in_eof,
  input  logic [7:0]       in_char,
  output logic [CNT_W-1:0] straight_count,
  output logic [CNT_W-1:0] x_count,
  output logic             done
);
  localparam int DEPTH = 3 * COLS + 3;
  localparam int CW    = $clog2(COLS);
  localparam logic [2:0] L_NONE = 3'd0, L_X = 3'd1, L_M = 3'd2, L_A = 3'd3, L_S = 3'd4;

  function automatic logic [2:0] encode(input logic [7:0] ch);
    case (ch)
      8'h58:   encode = L_X;
      8'h4D:   encode = L_M;
      8'h41:   encode = L_A;
      8'h53:   encode = L_S;
      default: encode = L_NONE;
    endcase
  endfunction

  function automatic logic word4(input logic [2:0] a, b, c, d);
    word4 = (a == L_X && b == L_M && c == L_A && d == L_S) ||
            (a == L_S && b == L_A && c == L_M && d == L_X);
  endfunction

  function automatic logic pair_ms(input logic [2:0] a, b);
    pair_ms = (a == L_M && b == L_S) || (a == L_S && b == L_M);
  endfunction

  logic [2:0]    cur;
  logic [2:0]    hist [1:DEPTH];
  logic [2:0]    w [0:3][0:3];
  logic [CW-1:0] col, col_e;
  logic [1:0]    row, row_e;

  assign cur   = encode(in_char);
  assign col_e = in_sof ? '0 : col;
  assign row_e = in_sof ? '0 : row;

  for (genvar k = 0; k < 4; k++) begin : g_row
    for (genvar j = 0; j < 4; j++) begin : g_col
      if (k == 0 && j == 0) begin : g_cur
        assign w[k][j] = cur;
      end else begin : g_old
        assign w[k][j] = hist[k * COLS + j];
      end
    end
  end

  always_ff @(posedge clk) begin
    if (in_valid) begin
      hist[1] <= cur;
      for (int i = 2; i <= DEPTH; i++) hist[i] <= hist[i-1];
    end
  end

  logic h_ok, v_ok, x_ok;
  logic m_h, m_v, m_d, m_a, m_x;
  logic [2:0] inc_s;

  assign h_ok  = col_e >= CW'(3);
  assign v_ok  = row_e == 2'd3;
  assign x_ok  = col_e >= CW'(2) && row_e >= 2'd2;

  assign m_h   = h_ok && word4(w[0][3], w[0][2], w[0][1], w[0][0]);
  assign m_v   = v_ok && word4(w[3][0], w[2][0], w[1][0], w[0][0]);
  assign m_d   = h_ok && v_ok && word4(w[3][3], w[2][2], w[1][1], w[0][0]);
  assign m_a   = h_ok && v_ok && word4(w[3][0], w[2][1], w[1][2], w[0][3]);
  assign m_x   = x_ok && w[1][1] == L_A && pair_ms(w[0][0], w[2][2]) && pair_ms(w[0][2], w[2][0]);
  assign inc_s = {2'b0, m_h} + {2'b0, m_v} + {2'b0, m_d} + {2'b0, m_a};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      col            <= '0;
      row            <= '0;
      straight_count <= '0;
      x_count        <= '0;
      done           <= 1'b0;
    end else begin
      done <= in_valid && in_eof;
      if (in_valid) begin
        if (col_e == CW'(COLS - 1)) begin
          col <= '0;
          row <= (row_e == 2'd3) ? row_e : row_e + 2'd1;
        end else begin
          col <= col_e + CW'(1);
          row <= row_e;
        end
        straight_count <= (in_sof ? '0 : straight_count) + CNT_W'(inc_s);
        x_count        <= (in_sof ? '0 : x_count) + CNT_W'(m_x);
      end
    end
  end

  a_r9_done_follows_eof: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(in_valid && in_eof));

  a_r8_sof_restarts: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_sof |=> straight_count == '0 && x_count == '0);

  a_r5_straight_step: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_sof |=> (straight_count - $past(straight_count)) <= CNT_W'(4));

  a_r6_x_step: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !in_sof |=> (x_count - $past(x_count)) <= CNT_W'(1));

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(straight_count) && $stable(x_count));
endmodule

// File: tb/tb_grid_word_counter.sv
module tb_grid_word_counter;
  localparam int COLS = 8;
  localparam int CNT_W = 16;
  localparam int MAXR = 8;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, in_sof = 1'b0, in_eof = 1'b0;
  logic [7:0] in_char = 8'h2E;
  logic [CNT_W-1:0] straight_count, x_count;
  logic done;

  grid_word_counter #(.COLS(COLS), .CNT_W(CNT_W)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_sof(in_sof), .in_eof(in_eof),
    .in_char(in_char), .straight_count(straight_count), .x_count(x_count), .done(done));

  always #(CLK_PERIOD / 2) clk = ~clk;

  int n_checks = 0, n_fails = 0;
  logic [7:0] g [0:MAXR-1][0:COLS-1];
  int nrows;

  task automatic check(input string req, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic logic [7:0] at(input int r, input int c);
    if (r < 0 || c < 0 || r >= nrows || c >= COLS) return 8'h2E;
    return g[r][c];
  endfunction

  function automatic int ref_straight();
    logic [7:0] word [4];
    int total, hit;
    word = '{8'h58, 8'h4D, 8'h41, 8'h53};
    total = 0;
    for (int r = 0; r < nrows; r++)
      for (int c = 0; c < COLS; c++)
        for (int dr = -1; dr <= 1; dr++)
          for (int dc = -1; dc <= 1; dc++) begin
            if (dr == 0 && dc == 0) continue;
            hit = 1;
            for (int i = 0; i < 4; i++)
              if (at(r + i * dr, c + i * dc) != word[i]) hit = 0;
            total += hit;
          end
    return total;
  endfunction

  function automatic int ref_x();
    int total = 0;
    for (int r = 1; r < nrows - 1; r++)
      for (int c = 1; c < COLS - 1; c++)
        if (g[r][c] == 8'h41 &&
            ((g[r-1][c-1] == 8'h4D && g[r+1][c+1] == 8'h53) || (g[r-1][c-1] == 8'h53 && g[r+1][c+1] == 8'h4D)) &&
            ((g[r-1][c+1] == 8'h4D && g[r+1][c-1] == 8'h53) || (g[r-1][c+1] == 8'h53 && g[r+1][c-1] == 8'h4D)))
          total++;
    return total;
  endfunction

  task automatic set_row(input int r, input string s);
    for (int c = 0; c < COLS; c++) g[r][c] = s[c];
  endtask

  function automatic logic [7:0] rand_char();
    case ($urandom_range(0, 5))
      0: return 8'h58;
      1: return 8'h4D;
      2: return 8'h41;
      3: return 8'h53;
      4: return 8'h61;
      default: return 8'h2E;
    endcase
  endfunction

  task automatic idle_gap(input int n);
    int s0, x0;
    @(negedge clk);
    in_valid = 1'b0; in_char = rand_char(); in_sof = $urandom_range(0, 1); in_eof = $urandom_range(0, 1);
    s0 = straight_count; x0 = x_count;
    for (int i = 1; i < n; i++) begin
      @(negedge clk);
      in_char = rand_char(); in_sof = $urandom_range(0, 1); in_eof = $urandom_range(0, 1);
    end
    @(negedge clk);
    in_sof = 1'b0; in_eof = 1'b0;
    check("R10 idle straight hold", straight_count, s0);
    check("R10 idle x hold", x_count, x0);
  endtask

  task automatic run_frame(input string tag, input bit gaps, input int es, input int ex);
    for (int r = 0; r < nrows; r++)
      for (int c = 0; c < COLS; c++) begin
        if (gaps && !(r == 0 && c == 0) && $urandom_range(0, 3) == 0) idle_gap($urandom_range(1, 3));
        else @(negedge clk);
        in_valid = 1'b1;
        in_char  = g[r][c];
        in_sof   = (r == 0 && c == 0);
        in_eof   = (r == nrows - 1 && c == COLS - 1);
      end
    @(negedge clk);
    in_valid = 1'b0; in_sof = 1'b0; in_eof = 1'b0;
    check({tag, " R9 done pulse"}, done, 1);
    check({tag, " straight vs model"}, straight_count, ref_straight());
    check({tag, " x vs model"}, x_count, ref_x());
    if (es >= 0) check({tag, " straight expected"}, straight_count, es);
    if (ex >= 0) check({tag, " x expected"}, x_count, ex);
    @(negedge clk);
    check({tag, " R9 done one cycle"}, done, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R8 reset straight", straight_count, 0);
    check("R8 reset x", x_count, 0);
    check("R9 reset done", done, 0);
    rst_n = 1'b1;

    nrows = 4;
    set_row(0, "xmasXmas"); set_row(1, "..mMaA.."); set_row(2, ".XMaS..."); set_row(3, "SAmX....");
    run_frame("R1 non-letters", 0, 0, 0);

    nrows = 1; set_row(0, "XMASSAMX");
    run_frame("R2 horizontal", 0, 2, 0);

    nrows = 4;
    set_row(0, "X......S"); set_row(1, "M......A"); set_row(2, "A......M"); set_row(3, "S......X");
    run_frame("R3 vertical", 0, 2, 0);

    set_row(0, "X......S"); set_row(1, ".M....A."); set_row(2, "..A..M.."); set_row(3, "...SX...");
    run_frame("R4 diagonals", 0, 2, 0);

    set_row(0, "X..S...."); set_row(1, ".MA....."); set_row(2, ".MA....."); set_row(3, "XMAS....");
    run_frame("R5 sum", 0, 3, 0);

    nrows = 3;
    set_row(0, "MXS.M.M."); set_row(1, "XAX..A.."); set_row(2, "MXS.M.M.");
    run_frame("R6 cross", 0, 0, 1);

    set_row(0, "S.M....."); set_row(1, ".A......"); set_row(2, "S.M.....");
    run_frame("R6 swapped", 0, 0, 1);

    set_row(0, "X......."); set_row(1, "M......."); set_row(2, "A.......");
    run_frame("R7 prior frame", 0, 0, 0);
    nrows = 2;
    set_row(0, "S.....XM"); set_row(1, "AS......");
    run_frame("R7 wrap", 0, 0, 0);

    nrows = 4;
    set_row(0, "XMASM.S."); set_row(1, "M.S..A.."); set_row(2, "AAA.M.S."); set_row(3, "SMSAMX..");
    run_frame("R10 gaps", 1, -1, -1);

    for (int t = 0; t < 60; t++) begin
      nrows = $urandom_range(3, MAXR);
      for (int r = 0; r < nrows; r++)
        for (int c = 0; c < COLS; c++) g[r][c] = rand_char();
      run_frame("R5 R6 random", t[0], -1, -1);
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end
endmodule